// File: doc/BRIEF.md
# Image Word Arithmetic and Logic Unit

This block treats each of two input words as a tiny binary image, one bit per pixel, and produces one processed image word of the same width. A 4-bit operation code picks one of fourteen operations: wrapping add, subtract and multiply, a left shift of either operand, bitwise logic, complement of either operand, unsigned division, and a squaring transform of either operand. Two codes are unused.

The result is captured in an output register on the rising clock edge. The operands and the code sampled at an edge decide the word shown after that edge. A synchronous active-high reset clears the register. The block has no handshake: a new operation can be presented every cycle, and the output holds until the next edge.

Top module: `imgword_alu`

## Requirements
- R1: The output changes only at a rising clock edge. After each edge it shows the result of the operands and the code sampled at that edge, and it holds unchanged between edges.
- R2: When `rst` is high at a rising edge, the output becomes 0 whatever the operands and code are.
- R3: Code 0000 gives (a + b) mod 2^16.
- R4: Code 0001 gives (a - b) mod 2^16.
- R5: Code 0010 shifts a left by one and code 0011 shifts b left by one. The top bit is dropped and bit 0 is filled with 0.
- R6: Bitwise logic: 0100 gives a OR b, 0101 gives a AND b, 1011 gives NOT(a OR b), and 1100 gives NOT(a AND b).
- R7: Code 1000 gives NOT a and code 1001 gives NOT b.
- R8: Code 1010 gives the unsigned quotient floor(a / b). When b is 0 the output is 16'hFFFF.
- R9: Code 1111 gives the low 16 bits of a * b.
- R10: Code 1101 gives the low 16 bits of a * a, and code 1110 gives the low 16 bits of b * b.
- R11: Codes 0110 and 0111 give an all-zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| pix_a | input | 16 | First image word (operand a) |
| pix_b | input | 16 | Second image word (operand b) |
| op_sel | input | 4 | Operation code |
| pix_out | output | 16 | Registered processed image word |

## Verification
The arithmetic codes are tried at the wrap points: all-ones plus one, zero minus one, and products whose high half is non-zero. These inputs separate true modular truncation from saturation or a widened result. Shifts use words with the top bit set, which shows whether that bit is dropped and whether the fill bit is zero. Division covers a zero divisor, a divisor larger than the dividend and an exact quotient, which separates the zero guard from plain floor division. A deterministic pseudo-random sweep over every code, including the unused ones, checks that each code selects its own result and not that of a neighbouring code.

// File: rtl/imgalu_pkg.sv
package imgalu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 4'b0000,
    OP_SUB    = 4'b0001,
    OP_SHL_A  = 4'b0010,
    OP_SHL_B  = 4'b0011,
    OP_OR     = 4'b0100,
    OP_AND    = 4'b0101,
    OP_RSV6   = 4'b0110,
    OP_RSV7   = 4'b0111,
    OP_NOT_A  = 4'b1000,
    OP_NOT_B  = 4'b1001,
    OP_DIV    = 4'b1010,
    OP_NOR    = 4'b1011,
    OP_NAND   = 4'b1100,
    OP_SQR_A  = 4'b1101,
    OP_SQR_B  = 4'b1110,
    OP_MUL    = 4'b1111
  } op_e;
endpackage

// File: rtl/imgalu_arith.sv
module imgalu_arith
  import imgalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  op_e          op,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic [W-1:0] shl_a,
  output logic [W-1:0] shl_b,
  output logic [W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mul_x;
  logic [W-1:0]  mul_y;
  logic [PW-1:0] mul_full;

  assign sum   = opa + opb;
  assign diff  = opa - opb;
  assign shl_a = {opa[W-2:0], 1'b0};
  assign shl_b = {opb[W-2:0], 1'b0};

  // One shared multiplier: the squaring codes steer the same operand to both inputs
  always_comb begin
    unique case (op)
      OP_SQR_A: begin mul_x = opa; mul_y = opa; end
      OP_SQR_B: begin mul_x = opb; mul_y = opb; end
      default:  begin mul_x = opa; mul_y = opb; end
    endcase
  end

  assign mul_full = PW'(mul_x) * PW'(mul_y);
  assign prod     = mul_full[W-1:0];
endmodule

// File: rtl/imgalu_logic.sv
module imgalu_logic
  import imgalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  op_e          op,
  output logic [W-1:0] res
);
  logic [W-1:0] or_v;
  logic [W-1:0] and_v;

  assign or_v  = opa | opb;
  assign and_v = opa & opb;

  always_comb begin
    unique case (op)
      OP_OR:    res = or_v;
      OP_AND:   res = and_v;
      OP_NOR:   res = ~or_v;
      OP_NAND:  res = ~and_v;
      OP_NOT_A: res = ~opa;
      OP_NOT_B: res = ~opb;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/imgalu_div.sv
module imgalu_div #(
  parameter int W = 16
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot
);
  logic div_zero;

  assign div_zero = (divisor == '0);
  // Zero divisor gives all ones, the value a restoring divider settles to
  assign quot = div_zero ? {W{1'b1}} : (dividend / divisor);
endmodule

// File: rtl/imgword_alu.sv
module imgword_alu
  import imgalu_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_a,
  input  logic [PIX_W-1:0] pix_b,
  input  logic [OP_W-1:0]  op_sel,
  output logic [PIX_W-1:0] pix_out
);
  op_e              op;
  logic [PIX_W-1:0] sum_w, diff_w, shla_w, shlb_w, prod_w;
  logic [PIX_W-1:0] logic_w, quot_w;
  logic [PIX_W-1:0] nxt;
  logic [PIX_W-1:0] out_q;

  assign op = op_e'(op_sel);

  imgalu_arith #(.W(PIX_W)) u_arith (
    .opa(pix_a), .opb(pix_b), .op(op),
    .sum(sum_w), .diff(diff_w), .shl_a(shla_w), .shl_b(shlb_w), .prod(prod_w)
  );

  imgalu_logic #(.W(PIX_W)) u_logic (
    .opa(pix_a), .opb(pix_b), .op(op), .res(logic_w)
  );

  imgalu_div #(.W(PIX_W)) u_div (
    .dividend(pix_a), .divisor(pix_b), .quot(quot_w)
  );

  always_comb begin
    unique case (op)
      OP_ADD:                                     nxt = sum_w;
      OP_SUB:                                     nxt = diff_w;
      OP_SHL_A:                                   nxt = shla_w;
      OP_SHL_B:                                   nxt = shlb_w;
      OP_OR, OP_AND, OP_NOR, OP_NAND,
      OP_NOT_A, OP_NOT_B:                         nxt = logic_w;
      OP_DIV:                                     nxt = quot_w;
      OP_SQR_A, OP_SQR_B, OP_MUL:                 nxt = prod_w;
      default:                                    nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= nxt;
  end

  assign pix_out = out_q;

  // R8: zero divisor yields all ones on the following cycle
  assert_div_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'b1010 && pix_b == '0) |=> (pix_out == {PIX_W{1'b1}}));

  // R11: unused codes give zero
  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'b0110 || op_sel == 4'b0111) |=> (pix_out == '0));

  // R7: complement of a appears one cycle later
  assert_not_a_R7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'b1000) |=> (pix_out == ~$past(pix_a)));

  // R6: AND result never sets a pixel absent from either operand
  assert_and_subset_R6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'b0101) |=> ((pix_out & ~($past(pix_a) & $past(pix_b))) == '0));

  // R5: shift of a always clears bit 0
  assert_shl_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'b0010) |=> (pix_out[0] == 1'b0));
endmodule

// File: tb/imgword_alu_tb.sv
module imgword_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pix_a = '0;
  logic [15:0] pix_b = '0;
  logic [3:0]  op_sel = '0;
  logic [15:0] pix_out;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  imgword_alu u_dut (
    .clk(clk), .rst(rst), .pix_a(pix_a), .pix_b(pix_b),
    .op_sel(op_sel), .pix_out(pix_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model(input logic [3:0] op,
                                        input logic [15:0] a,
                                        input logic [15:0] b);
    logic [31:0] p;
    case (op)
      4'b0000: return a + b;
      4'b0001: return a - b;
      4'b0010: return {a[14:0], 1'b0};
      4'b0011: return {b[14:0], 1'b0};
      4'b0100: return a | b;
      4'b0101: return a & b;
      4'b1000: return ~a;
      4'b1001: return ~b;
      4'b1010: return (b == 16'd0) ? 16'hFFFF : a / b;
      4'b1011: return ~(a | b);
      4'b1100: return ~(a & b);
      4'b1101: begin p = {16'd0, a} * {16'd0, a}; return p[15:0]; end
      4'b1110: begin p = {16'd0, b} * {16'd0, b}; return p[15:0]; end
      4'b1111: begin p = {16'd0, a} * {16'd0, b}; return p[15:0]; end
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000: return "R3";
      4'b0001: return "R4";
      4'b0010, 4'b0011: return "R5";
      4'b0100, 4'b0101, 4'b1011, 4'b1100: return "R6";
      4'b1000, 4'b1001: return "R7";
      4'b1010: return "R8";
      4'b1111: return "R9";
      4'b1101, 4'b1110: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one register)
  task automatic run_op(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op_sel = op; pix_a = a; pix_b = b;
    @(negedge clk);
    check(tag_of(op), pix_out, model(op, a, b));
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; op_sel = 4'b1000; pix_a = 16'h0000; pix_b = 16'h1234;
    @(negedge clk);
    check("R2", pix_out, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1", pix_out, 16'hFFFF);
    rst = 1'b1;
    @(negedge clk);
    check("R2", pix_out, 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    run_op(4'b0000, 16'h0001, 16'h0002);
    op_sel = 4'b0100; pix_a = 16'hF0F0; pix_b = 16'h0F0F;
    #1;
    check("R1", pix_out, 16'h0003);
    @(negedge clk);
    check("R1", pix_out, 16'hFFFF);
  endtask

  task automatic t_add;
    run_op(4'b0000, 16'hFFFF, 16'h0001);
    run_op(4'b0000, 16'h8000, 16'h8000);
    run_op(4'b0000, 16'h1234, 16'h4321);
  endtask

  task automatic t_sub;
    run_op(4'b0001, 16'h0000, 16'h0001);
    run_op(4'b0001, 16'h5000, 16'h1234);
  endtask

  task automatic t_shift;
    run_op(4'b0010, 16'h8001, 16'h0000);
    run_op(4'b0011, 16'h0000, 16'hC003);
    run_op(4'b0010, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_logic;
    run_op(4'b0100, 16'hAA00, 16'h0A0A);
    run_op(4'b0101, 16'hAA00, 16'h0A0A);
    run_op(4'b1011, 16'hAA00, 16'h0A0A);
    run_op(4'b1100, 16'hAA00, 16'h0A0A);
  endtask

  task automatic t_compl;
    run_op(4'b1000, 16'h00FF, 16'h1234);
    run_op(4'b1001, 16'h00FF, 16'h1234);
  endtask

  task automatic t_div;
    run_op(4'b1010, 16'h1234, 16'h0000);
    run_op(4'b1010, 16'h0005, 16'h0009);
    run_op(4'b1010, 16'hFFFF, 16'h0003);
    run_op(4'b1010, 16'h0064, 16'h0007);
  endtask

  task automatic t_mul;
    run_op(4'b1111, 16'h0100, 16'h0100);
    run_op(4'b1111, 16'h00FF, 16'h0101);
    run_op(4'b1111, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_square;
    run_op(4'b1101, 16'h0101, 16'h0003);
    run_op(4'b1110, 16'h0003, 16'h0101);
    run_op(4'b1101, 16'h8000, 16'h0000);
  endtask

  task automatic t_unused;
    run_op(4'b0110, 16'hFFFF, 16'hFFFF);
    run_op(4'b0111, 16'h1234, 16'h5678);
  endtask

  task automatic t_sweep;
    logic [15:0] a, b;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = (k % 17 == 0) ? 16'h0000 : lfsr;
      run_op(4'(k % 16), a, b);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_latency();
    t_add();
    t_sub();
    t_shift();
    t_logic();
    t_compl();
    t_div();
    t_mul();
    t_square();
    t_unused();
    t_sweep();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule